// File: doc/BRIEF.md
# Processor Status and Stack-Bank Register

This block holds the live processor status flags (stack mode, interrupt enable, condition) and their backup copies, all packed into one 32-bit status word. It also holds a saved program counter for exception handling and two physical stack pointers, one for the interrupt context and one for the user context. The general register that serves as the stack pointer is an alias: the live stack-mode flag decides which of the two physical pointers it reaches.

Software reaches every register through a control-register port addressed by a small register number. Dedicated per-flag set and clear requests give single-flag updates without a read-modify-write. A read-only mirror register shows the condition flag on its own.

The pipeline drives two events. Exception entry copies the live flags into the backup field, clears interrupt enable and saves a program counter. Return from exception copies the backup field back into the live flags and presents the saved program counter, word aligned, for the fetch unit to restore.

Top module: `status_stack_regs`

## Requirements
- R1: Status word (register number 0) layout in Verilog bit indices: stack mode at bit 7, interrupt enable at bit 6, condition at bit 0, backup stack mode at bit 15, backup interrupt enable at bit 14, backup condition at bit 8. Every other bit reads 0 and ignores writes. After reset the whole word reads 0.
- R2: A control-register write to number 0 loads all six defined flags from the write data in one cycle.
- R3: Exception entry copies the live stack mode, interrupt enable and condition into the backup positions, clears interrupt enable, and keeps stack mode and condition. Set, clear, write and return requests made in that same cycle have no effect on the status word.
- R4: Return from exception (without entry in the same cycle) copies the backup flags into the live flags and leaves the backup flags unchanged.
- R5: Saved PC (register number 6): on exception entry it captures `exc_pc_next` when `exc_save_next`=1 and `exc_pc_fault` otherwise, with bit 0 forced to 0. A control-register write stores the write data with bit 0 forced to 0, and entry wins over a write in the same cycle. `ret_pc` always equals the saved PC with bits 1:0 forced to 00.
- R6: Condition mirror (register number 1) reads the condition flag in bit 0 and zeros elsewhere. Writes to it have no effect, and it reads 0 after reset.
- R7: Stack-pointer alias: while stack mode is 0 the alias reads and writes the interrupt stack pointer (number 2); while it is 1, the user stack pointer (number 3). An alias write uses the stack-mode value held before the clock edge. Both pointers read 0 after reset.
- R8: `bit_set_req`/`bit_clr_req` index 2 = stack mode, 1 = interrupt enable, 0 = condition. The new live flags are (old & ~clear) | set, so set wins over clear. These requests apply on top of a number-0 write in the same cycle.
- R9: Register numbers other than 0, 1, 2, 3 and 6 read 0, and writes to them change no register.
- R10: When a control-register write and an alias write hit the same stack pointer in one cycle, the control-register data is stored.
- R11: `stack_mode`, `int_enable` and `cond_flag` always equal the live flags in the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_sel | input | CRN_W | Control-register number |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_wdata | input | 32 | Control-register write data |
| cr_rdata | output | 32 | Control-register read data (combinational) |
| bit_set_req | input | 3 | Per-flag set requests (2 stack mode, 1 int enable, 0 condition) |
| bit_clr_req | input | 3 | Per-flag clear requests, same indexing |
| sp_alias_we | input | 1 | Write strobe for the stack-pointer alias |
| sp_alias_wdata | input | 32 | Alias write data |
| sp_alias_rdata | output | 32 | Alias read data |
| exc_enter | input | 1 | Exception-entry event |
| exc_save_next | input | 1 | 1 saves next-instruction PC, 0 saves faulting PC |
| exc_pc_fault | input | 32 | PC of the faulting instruction |
| exc_pc_next | input | 32 | PC of the next instruction |
| exc_return | input | 1 | Return-from-exception event |
| stack_mode | output | 1 | Live stack-mode flag |
| int_enable | output | 1 | Live interrupt-enable flag |
| cond_flag | output | 1 | Live condition flag |
| ret_pc | output | 32 | Word-aligned PC to restore on return |

## Verification
The risky overlap is an exception entry landing in the same cycle as a software update of the status word: a set request, a full write or a return. The bench sweeps every live/backup flag pairing and raises entry together with an all-ones set request, and once together with a return. It judges the outcome against the entry-only result computed from the prior flags. A second overlap, a stack-mode change in the same cycle as an alias write, is provoked by setting stack mode while writing the alias. The bench then confirms that the data reached the interrupt pointer and that later alias reads see the user pointer.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int DW      = 32;
    localparam int NUM_SP  = 2;

    // Flag positions inside the status word (Verilog indices)
    localparam int SM_POS  = 7;
    localparam int IE_POS  = 6;
    localparam int C_POS   = 0;
    localparam int BSM_POS = 15;
    localparam int BIE_POS = 14;
    localparam int BC_POS  = 8;

    // Control-register numbers
    localparam int CRN_STATUS = 0;
    localparam int CRN_COND   = 1;
    localparam int CRN_ISP    = 2;
    localparam int CRN_USP    = 3;
    localparam int CRN_SAVPC  = 6;

    // Flag triple; packed order matches set/clear request indexing
    typedef struct packed {
        logic sm;
        logic ie;
        logic c;
    } flags_t;

    function automatic logic [DW-1:0] pack_word(input flags_t live, input flags_t bk);
        logic [DW-1:0] w;
        w          = '0;
        w[SM_POS]  = live.sm;
        w[IE_POS]  = live.ie;
        w[C_POS]   = live.c;
        w[BSM_POS] = bk.sm;
        w[BIE_POS] = bk.ie;
        w[BC_POS]  = bk.c;
        return w;
    endfunction

    function automatic flags_t live_of(input logic [DW-1:0] w);
        flags_t f;
        f.sm = w[SM_POS];
        f.ie = w[IE_POS];
        f.c  = w[C_POS];
        return f;
    endfunction

    function automatic flags_t backup_of(input logic [DW-1:0] w);
        flags_t f;
        f.sm = w[BSM_POS];
        f.ie = w[BIE_POS];
        f.c  = w[BC_POS];
        return f;
    endfunction

    function automatic flags_t apply_setclr(input flags_t f, input logic [2:0] set_m,
                                            input logic [2:0] clr_m);
        return flags_t'((f & ~clr_m) | set_m);
    endfunction

endpackage

// File: rtl/psw_status_unit.sv
module psw_status_unit
    import psw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          exc_enter,
    input  logic          exc_return,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    set_req,
    input  logic [2:0]    clr_req,
    output flags_t        live,
    output flags_t        backup
);

    flags_t live_q, bk_q, live_n, bk_n;

    always_comb begin
        live_n = live_q;
        bk_n   = bk_q;
        if (exc_enter) begin
            bk_n      = live_q;
            live_n.ie = 1'b0;
        end else if (exc_return) begin
            live_n = bk_q;
        end else begin
            if (wr_en) begin
                live_n = live_of(wdata);
                bk_n   = backup_of(wdata);
            end
            live_n = apply_setclr(live_n, set_req, clr_req);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            bk_q   <= '0;
        end else begin
            live_q <= live_n;
            bk_q   <= bk_n;
        end
    end

    assign live   = live_q;
    assign backup = bk_q;

endmodule

// File: rtl/psw_sp_bank.sv
module psw_sp_bank
    import psw_pkg::*;
#(
    parameter int W = DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_user,
    input  logic              alias_we,
    input  logic [W-1:0]      alias_wdata,
    input  logic [NUM_SP-1:0] cr_we,
    input  logic [W-1:0]      cr_wdata,
    output logic [W-1:0]      isp,
    output logic [W-1:0]      usp,
    output logic [W-1:0]      alias_rdata
);

    logic [W-1:0] sp_q [NUM_SP];

    for (genvar g = 0; g < NUM_SP; g++) begin : g_sp
        logic alias_hit;
        assign alias_hit = alias_we && (int'(sel_user) == g);
        always_ff @(posedge clk) begin
            if (rst)
                sp_q[g] <= '0;
            else if (cr_we[g])
                sp_q[g] <= cr_wdata;
            else if (alias_hit)
                sp_q[g] <= alias_wdata;
        end
    end

    assign isp         = sp_q[0];
    assign usp         = sp_q[1];
    assign alias_rdata = sel_user ? sp_q[1] : sp_q[0];

endmodule

// File: rtl/psw_saved_pc.sv
module psw_saved_pc
    import psw_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exc_enter,
    input  logic         save_next,
    input  logic [W-1:0] pc_fault,
    input  logic [W-1:0] pc_next,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] saved_pc,
    output logic [W-1:0] ret_pc
);

    logic [W-1:0] pc_q;
    logic [W-1:0] capture;

    assign capture = save_next ? pc_next : pc_fault;

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else if (exc_enter)
            pc_q <= {capture[W-1:1], 1'b0};
        else if (wr_en)
            pc_q <= {wdata[W-1:1], 1'b0};
    end

    assign saved_pc = pc_q;
    assign ret_pc   = {pc_q[W-1:2], 2'b00};

endmodule

// File: rtl/status_stack_regs.sv
module status_stack_regs
    import psw_pkg::*;
#(
    parameter int CRN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CRN_W-1:0] cr_sel,
    input  logic             cr_wr_en,
    input  logic [DW-1:0]    cr_wdata,
    output logic [DW-1:0]    cr_rdata,
    input  logic [2:0]       bit_set_req,
    input  logic [2:0]       bit_clr_req,
    input  logic             sp_alias_we,
    input  logic [DW-1:0]    sp_alias_wdata,
    output logic [DW-1:0]    sp_alias_rdata,
    input  logic             exc_enter,
    input  logic             exc_save_next,
    input  logic [DW-1:0]    exc_pc_fault,
    input  logic [DW-1:0]    exc_pc_next,
    input  logic             exc_return,
    output logic             stack_mode,
    output logic             int_enable,
    output logic             cond_flag,
    output logic [DW-1:0]    ret_pc
);

    localparam logic [CRN_W-1:0] SEL_STATUS = CRN_W'(CRN_STATUS);
    localparam logic [CRN_W-1:0] SEL_COND   = CRN_W'(CRN_COND);
    localparam logic [CRN_W-1:0] SEL_ISP    = CRN_W'(CRN_ISP);
    localparam logic [CRN_W-1:0] SEL_USP    = CRN_W'(CRN_USP);
    localparam logic [CRN_W-1:0] SEL_SAVPC  = CRN_W'(CRN_SAVPC);

    flags_t            live, backup;
    logic [DW-1:0]     status_word;
    logic [DW-1:0]     isp, usp, saved_pc;
    logic [NUM_SP-1:0] sp_cr_we;
    logic              status_we, savpc_we;

    assign status_we   = cr_wr_en && (cr_sel == SEL_STATUS);
    assign savpc_we    = cr_wr_en && (cr_sel == SEL_SAVPC);
    assign sp_cr_we[0] = cr_wr_en && (cr_sel == SEL_ISP);
    assign sp_cr_we[1] = cr_wr_en && (cr_sel == SEL_USP);

    psw_status_unit u_status (
        .clk        (clk),
        .rst        (rst),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .wr_en      (status_we),
        .wdata      (cr_wdata),
        .set_req    (bit_set_req),
        .clr_req    (bit_clr_req),
        .live       (live),
        .backup     (backup)
    );

    psw_sp_bank #(.W(DW)) u_sp (
        .clk         (clk),
        .rst         (rst),
        .sel_user    (live.sm),
        .alias_we    (sp_alias_we),
        .alias_wdata (sp_alias_wdata),
        .cr_we       (sp_cr_we),
        .cr_wdata    (cr_wdata),
        .isp         (isp),
        .usp         (usp),
        .alias_rdata (sp_alias_rdata)
    );

    psw_saved_pc #(.W(DW)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .exc_enter (exc_enter),
        .save_next (exc_save_next),
        .pc_fault  (exc_pc_fault),
        .pc_next   (exc_pc_next),
        .wr_en     (savpc_we),
        .wdata     (cr_wdata),
        .saved_pc  (saved_pc),
        .ret_pc    (ret_pc)
    );

    assign status_word = pack_word(live, backup);

    always_comb begin
        if (cr_sel == SEL_STATUS)
            cr_rdata = status_word;
        else if (cr_sel == SEL_COND)
            cr_rdata = {{(DW-1){1'b0}}, live.c};
        else if (cr_sel == SEL_ISP)
            cr_rdata = isp;
        else if (cr_sel == SEL_USP)
            cr_rdata = usp;
        else if (cr_sel == SEL_SAVPC)
            cr_rdata = saved_pc;
        else
            cr_rdata = '0;
    end

    assign stack_mode = live.sm;
    assign int_enable = live.ie;
    assign cond_flag  = live.c;

endmodule

// File: rtl/status_stack_regs_chk.sv
module status_stack_regs_chk
    import psw_pkg::*;
#(
    parameter int CRN_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             exc_enter,
    input logic             exc_return,
    input logic [2:0]       bit_set_req,
    input logic [2:0]       bit_clr_req,
    input logic             cr_wr_en,
    input logic [CRN_W-1:0] cr_sel,
    input logic [DW-1:0]    cr_rdata,
    input logic [DW-1:0]    sp_alias_rdata,
    input logic             stack_mode,
    input logic             int_enable,
    input logic             cond_flag,
    input logic [DW-1:0]    ret_pc,
    input logic [DW-1:0]    status_word
);

    localparam logic [DW-1:0] DEFINED = (DW'(1) << SM_POS) | (DW'(1) << IE_POS) |
                                        (DW'(1) << C_POS)  | (DW'(1) << BSM_POS) |
                                        (DW'(1) << BIE_POS) | (DW'(1) << BC_POS);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (status_word & ~DEFINED) == '0);  // R1

    AST_ENTRY_SAVES_FLAGS: assert property (@(posedge clk) disable iff (rst)
        exc_enter |=> (status_word[BSM_POS] == $past(stack_mode)) &&
                      (status_word[BIE_POS] == $past(int_enable)) &&
                      (status_word[BC_POS]  == $past(cond_flag)) &&
                      !int_enable && (stack_mode == $past(stack_mode)) &&
                      (cond_flag == $past(cond_flag)));  // R3

    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (exc_return && !exc_enter) |=>
            (stack_mode == $past(status_word[BSM_POS])) &&
            (int_enable == $past(status_word[BIE_POS])) &&
            (cond_flag  == $past(status_word[BC_POS])));  // R4

    AST_RETPC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        ret_pc[1:0] == 2'b00);  // R5

    AST_MIRROR_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (cr_sel == CRN_W'(CRN_COND)) |-> (cr_rdata == {{(DW-1){1'b0}}, cond_flag}));  // R6

    AST_ALIAS_USER: assert property (@(posedge clk) disable iff (rst)
        (stack_mode && cr_sel == CRN_W'(CRN_USP)) |-> (sp_alias_rdata == cr_rdata));  // R7

    AST_ALIAS_INTR: assert property (@(posedge clk) disable iff (rst)
        (!stack_mode && cr_sel == CRN_W'(CRN_ISP)) |-> (sp_alias_rdata == cr_rdata));  // R7

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!exc_enter && !exc_return && bit_set_req == 3'b000 && bit_clr_req == 3'b000 &&
         !(cr_wr_en && cr_sel == CRN_W'(CRN_STATUS)))
        |=> $stable({stack_mode, int_enable, cond_flag}));  // R8

    AST_OUTPUTS_MATCH: assert property (@(posedge clk) disable iff (rst)
        {stack_mode, int_enable, cond_flag} ==
        {status_word[SM_POS], status_word[IE_POS], status_word[C_POS]});  // R11

endmodule

bind status_stack_regs status_stack_regs_chk #(.CRN_W(CRN_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .exc_enter      (exc_enter),
    .exc_return     (exc_return),
    .bit_set_req    (bit_set_req),
    .bit_clr_req    (bit_clr_req),
    .cr_wr_en       (cr_wr_en),
    .cr_sel         (cr_sel),
    .cr_rdata       (cr_rdata),
    .sp_alias_rdata (sp_alias_rdata),
    .stack_mode     (stack_mode),
    .int_enable     (int_enable),
    .cond_flag      (cond_flag),
    .ret_pc         (ret_pc),
    .status_word    (status_word)
);

// File: tb/status_stack_regs_test.sv
module status_stack_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cr_sel = '0;
    logic        cr_wr_en = 1'b0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic [2:0]  bit_set_req = '0;
    logic [2:0]  bit_clr_req = '0;
    logic        sp_alias_we = 1'b0;
    logic [31:0] sp_alias_wdata = '0;
    logic [31:0] sp_alias_rdata;
    logic        exc_enter = 1'b0;
    logic        exc_save_next = 1'b0;
    logic [31:0] exc_pc_fault = '0;
    logic [31:0] exc_pc_next = '0;
    logic        exc_return = 1'b0;
    logic        stack_mode, int_enable, cond_flag;
    logic [31:0] ret_pc;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    status_stack_regs #(.CRN_W(3)) uut (
        .clk(clk), .rst(rst), .cr_sel(cr_sel), .cr_wr_en(cr_wr_en), .cr_wdata(cr_wdata),
        .cr_rdata(cr_rdata), .bit_set_req(bit_set_req), .bit_clr_req(bit_clr_req),
        .sp_alias_we(sp_alias_we), .sp_alias_wdata(sp_alias_wdata),
        .sp_alias_rdata(sp_alias_rdata), .exc_enter(exc_enter),
        .exc_save_next(exc_save_next), .exc_pc_fault(exc_pc_fault),
        .exc_pc_next(exc_pc_next), .exc_return(exc_return), .stack_mode(stack_mode),
        .int_enable(int_enable), .cond_flag(cond_flag), .ret_pc(ret_pc)
    );

    // Status word per R1: live {sm,ie,c} at 7,6,0; backup at 15,14,8
    function automatic logic [31:0] mk(input logic [2:0] l, input logic [2:0] b);
        logic [31:0] w = '0;
        w[7] = l[2]; w[6] = l[1]; w[0] = l[0];
        w[15] = b[2]; w[14] = b[1]; w[8] = b[0];
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] n, output logic [31:0] d);
        cr_sel = n;
        #1;
        d = cr_rdata;
    endtask

    task automatic wr(input logic [2:0] n, input logic [31:0] d);
        @(negedge clk);
        cr_sel = n; cr_wr_en = 1'b1; cr_wdata = d;
        @(negedge clk);
        cr_wr_en = 1'b0;
    endtask

    task automatic setclr(input logic [2:0] s, input logic [2:0] c);
        @(negedge clk);
        bit_set_req = s; bit_clr_req = c;
        @(negedge clk);
        bit_set_req = '0; bit_clr_req = '0;
    endtask

    task automatic flags_chk(input string req, input logic [2:0] l);
        chk(req, {29'b0, stack_mode, int_enable, cond_flag}, {29'b0, l});
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d, noise, isp_v, usp_v, pc_v;
        noise = ~mk(3'b111, 3'b111);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state: R1, R5, R6, R7
        rd(0, d); chk("R1 reset status", d, 32'h0);
        rd(1, d); chk("R6 reset mirror", d, 32'h0);
        rd(2, d); chk("R7 reset isp", d, 32'h0);
        rd(3, d); chk("R7 reset usp", d, 32'h0);
        rd(6, d); chk("R5 reset saved pc", d, 32'h0);
        chk("R5 reset ret_pc", ret_pc, 32'h0);

        // R1/R2: all 64 flag patterns, reserved bits written as ones
        for (int v = 0; v < 64; v++) begin
            wr(0, mk(v[5:3], v[2:0]) | noise);
            rd(0, d); chk("R2 status write", d, mk(v[5:3], v[2:0]));
            flags_chk("R11 outputs", v[5:3]);
            rd(1, d); chk("R6 mirror", d, {31'b0, v[3]});
        end

        // R8: every start x set x clear combination
        for (int l = 0; l < 8; l++)
            for (int s = 0; s < 8; s++)
                for (int c = 0; c < 8; c++) begin
                    wr(0, mk(l[2:0], 3'b101));
                    setclr(s[2:0], c[2:0]);
                    rd(0, d);
                    chk("R8 set/clear", d, mk((l[2:0] & ~c[2:0]) | s[2:0], 3'b101));
                end

        // R8: write and set/clear in the same cycle
        @(negedge clk);
        cr_sel = 0; cr_wr_en = 1'b1; cr_wdata = mk(3'b010, 3'b011);
        bit_set_req = 3'b001; bit_clr_req = 3'b010;
        @(negedge clk);
        cr_wr_en = 1'b0; bit_set_req = '0; bit_clr_req = '0;
        rd(0, d); chk("R8 write plus set/clear", d, mk(3'b001, 3'b011));

        // R3/R4: entry with overlapping set request, then return
        for (int l = 0; l < 8; l++)
            for (int b = 0; b < 8; b++) begin
                wr(0, mk(l[2:0], b[2:0]));
                @(negedge clk);
                exc_enter = 1'b1; bit_set_req = 3'b111;
                @(negedge clk);
                exc_enter = 1'b0; bit_set_req = '0;
                rd(0, d);
                chk("R3 entry", d, mk({l[2], 1'b0, l[0]}, l[2:0]));
                @(negedge clk);
                exc_return = 1'b1;
                @(negedge clk);
                exc_return = 1'b0;
                rd(0, d); chk("R4 return", d, mk(l[2:0], l[2:0]));
                flags_chk("R11 after return", l[2:0]);
            end

        // R3: entry and return together, entry wins
        wr(0, mk(3'b110, 3'b001));
        @(negedge clk);
        exc_enter = 1'b1; exc_return = 1'b1;
        @(negedge clk);
        exc_enter = 1'b0; exc_return = 1'b0;
        rd(0, d); chk("R3 entry beats return", d, mk(3'b100, 3'b110));

        // R6: mirror writes ignored
        wr(0, mk(3'b001, 3'b000));
        wr(1, 32'h0);
        rd(1, d); chk("R6 mirror write ignored", d, 32'h1);
        rd(0, d); chk("R6 status after mirror write", d, mk(3'b001, 3'b000));

        // R5: saved PC capture, both selections
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            exc_enter = 1'b1; exc_save_next = k[0];
            exc_pc_fault = 32'h1234_5677; exc_pc_next = 32'hABCD_EF03;
            cr_sel = 6; cr_wr_en = 1'b1; cr_wdata = 32'h5555_5555;
            @(negedge clk);
            exc_enter = 1'b0; cr_wr_en = 1'b0;
            pc_v = k[0] ? 32'hABCD_EF02 : 32'h1234_5676;
            rd(6, d); chk("R5 capture", d, pc_v);
            chk("R5 ret_pc", ret_pc, {pc_v[31:2], 2'b00});
        end
        wr(6, 32'hFFFF_FFFF);
        rd(6, d); chk("R5 write bit0", d, 32'hFFFF_FFFE);
        chk("R5 ret_pc after write", ret_pc, 32'hFFFF_FFFC);

        // R7: alias steering
        wr(0, 32'h0);
        @(negedge clk); sp_alias_we = 1'b1; sp_alias_wdata = 32'h1111_0000;
        @(negedge clk); sp_alias_we = 1'b0;
        rd(2, d); chk("R7 alias to isp", d, 32'h1111_0000);
        rd(3, d); chk("R7 usp untouched", d, 32'h0);
        chk("R7 alias read isp", sp_alias_rdata, 32'h1111_0000);
        // stack mode set in the same cycle as an alias write: old mode applies
        @(negedge clk);
        bit_set_req = 3'b100; sp_alias_we = 1'b1; sp_alias_wdata = 32'h2222_0000;
        @(negedge clk);
        bit_set_req = '0; sp_alias_we = 1'b0;
        rd(2, d); chk("R7 same-cycle mode change", d, 32'h2222_0000);
        chk("R7 alias now user", sp_alias_rdata, 32'h0);
        @(negedge clk); sp_alias_we = 1'b1; sp_alias_wdata = 32'h3333_0000;
        @(negedge clk); sp_alias_we = 1'b0;
        rd(3, d); chk("R7 alias to usp", d, 32'h3333_0000);
        rd(2, d); chk("R7 isp kept", d, 32'h2222_0000);

        // R10: CR write and alias write on the same pointer
        @(negedge clk);
        cr_sel = 3; cr_wr_en = 1'b1; cr_wdata = 32'h4444_0000;
        sp_alias_we = 1'b1; sp_alias_wdata = 32'h5555_0000;
        @(negedge clk);
        cr_wr_en = 1'b0; sp_alias_we = 1'b0;
        rd(3, d); chk("R10 cr write wins", d, 32'h4444_0000);

        // R9: unused numbers
        rd(2, isp_v); rd(3, usp_v);
        wr(0, mk(3'b101, 3'b010));
        for (int n = 4; n < 8; n++) begin
            if (n == 6) continue;
            wr(n[2:0], 32'hFFFF_FFFF);
            rd(n[2:0], d); chk("R9 unused reads zero", d, 32'h0);
        end
        rd(0, d); chk("R9 status unchanged", d, mk(3'b101, 3'b010));
        rd(2, d); chk("R9 isp unchanged", d, isp_v);
        rd(3, d); chk("R9 usp unchanged", d, usp_v);
        rd(6, d); chk("R9 saved pc unchanged", d, 32'hFFFF_FFFE);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule